// File: doc/BRIEF.md
# NOR Flash Erase Sequencer

This block runs an erase on a parallel NOR flash through a simple memory-bus master. A one-cycle start pulse captures a target address, an erase mode (sector, block or whole chip) and a command-set variant. The block then issues the six-write erase command, with five fixed unlock and setup writes and one final write whose code and address depend on the mode. After that it polls the device status until the operation settles, and raises a done flag, with an error flag beside it when the device reports an expired internal timer.

Two command-set variants are handled. The standard variant (algo code 0) accepts sector and chip erase and watches the timing-limit status bit while polling. The extended variant (algo code 1) also accepts block erase and never looks at that bit. When a mode is requested that the selected variant cannot perform, or when the reserved mode code is used, the block performs a sector erase instead. Every bus access holds its strobe, address and data until the bus acknowledges it.

Top module: `nor_erase_seq`

## Requirements
- R1: An accepted start produces exactly six writes. The first five are, in order, data 0xAA to address 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555 and 0x55 to 0x2AA.
- R2: Mode code 2'b00 (sector) writes 0x30 as the sixth write, to the captured target address, under either variant.
- R3: Mode code 2'b01 (block) under the extended variant (algo 1) writes 0x50 as the sixth write, to the target address.
- R4: Mode code 2'b10 (chip) writes 0x10 as the sixth write, to address 0x555, under both variants.
- R5: Mode code 2'b01 under the standard variant (algo 0) falls back to sector erase: the sixth write is 0x30 to the target address.
- R6: The reserved mode code 2'b11 performs a sector erase under both variants.
- R7: After the sixth write, the block reads status at the target address. It finishes with done set and error clear on the first read whose bit 6 equals bit 6 of the read just before it, so a device that toggles for T reads is read T+1 times.
- R8: Under the standard variant, a toggling read with status bit 5 set triggers exactly one more read. If bit 6 toggles again on that read, the block ends with both done and error set.
- R9: Under the standard variant, if the extra read after bit 5 shows bit 6 unchanged, the block ends with done set and error clear.
- R10: Under the extended variant, status bit 5 has no effect. Polling continues until bit 6 stops toggling, and error stays clear.
- R11: A write or read strobe, together with its address and write data, stays asserted and unchanged until a cycle in which acknowledge is high. The next access starts only after that cycle.
- R12: After reset, busy, done, error and both strobes are low. A start raised while busy is ignored. An accepted start clears done and error and raises busy on the next cycle.
- R13: The write and read strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| mode_i | input | 2 | Erase mode: 00 sector, 01 block, 10 chip, 11 reserved |
| algo_i | input | 1 | Command-set variant: 0 standard, 1 extended |
| base_i | input | ADDR_W (24) | Target sector or block address |
| bus_addr_o | output | ADDR_W (24) | Bus address |
| bus_wdata_o | output | DATA_W (16) | Bus write data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_rdata_i | input | DATA_W (16) | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Bus acknowledge for the current access |
| busy_o | output | 1 | Erase in progress |
| done_o | output | 1 | Last erase finished; held until the next start |
| err_o | output | 1 | Last erase ended on an expired timing limit |

## Verification
The hardest case to reach is the timing-limit branch. There the device must raise bit 5 on a read that is still toggling, and the single confirming read must then either toggle once more or settle. The bench's flash model scripts each read's status from two per-test numbers: how many reads toggle, and the read index from which bit 5 is set. This places the bit-5 event on exactly the read that needs it, with the confirm read settled or still toggling. A second hard spot is a start arriving mid-sequence. The model inserts wait states so the command phase lasts long enough to pulse a chip-erase start inside it, and the bench then confirms that the written sequence remains the original sector erase.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

  typedef enum logic [1:0] {
    ERS_SECTOR = 2'd0,
    ERS_BLOCK  = 2'd1,
    ERS_CHIP   = 2'd2,
    ERS_RSVD   = 2'd3
  } ers_mode_e;

  typedef enum logic {
    ALG_STD = 1'b0,
    ALG_EXT = 1'b1
  } ers_alg_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_POLL = 2'd2,
    ST_CONF = 2'd3
  } ers_state_e;

  localparam logic [7:0] CB_KEY1   = 8'hAA;
  localparam logic [7:0] CB_KEY2   = 8'h55;
  localparam logic [7:0] CB_ARM    = 8'h80;
  localparam logic [7:0] CB_CHIP   = 8'h10;
  localparam logic [7:0] CB_SECTOR = 8'h30;
  localparam logic [7:0] CB_BLOCK  = 8'h50;

  function automatic logic [7:0] final_code(ers_mode_e m);
    case (m)
      ERS_CHIP:  final_code = CB_CHIP;
      ERS_BLOCK: final_code = CB_BLOCK;
      default:   final_code = CB_SECTOR;
    endcase
  endfunction

endpackage

// File: rtl/nor_rst_sync.sv
module nor_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign arst_n = sync_q[STAGES-1];
endmodule

// File: rtl/nor_mode_resolve.sv
module nor_mode_resolve
  import nor_erase_pkg::*;
(
  input  ers_mode_e req_mode,
  input  ers_alg_e  alg,
  output ers_mode_e eff_mode
);
  always_comb begin
    case (req_mode)
      ERS_CHIP:  eff_mode = ERS_CHIP;
      ERS_BLOCK: eff_mode = (alg == ALG_EXT) ? ERS_BLOCK : ERS_SECTOR;
      default:   eff_mode = ERS_SECTOR;
    endcase
  end
endmodule

// File: rtl/nor_cmd_table.sv
module nor_cmd_table
  import nor_erase_pkg::*;
#(
  parameter int                ADDR_W   = 24,
  parameter int                DATA_W   = 16,
  parameter int                IDX_W    = 3,
  parameter logic [ADDR_W-1:0] UNLOCK_A = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_B = 'h2AA
) (
  input  logic [IDX_W-1:0]  idx,
  input  ers_mode_e         mode,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic [7:0] code;

  always_comb begin
    case (idx)
      IDX_W'(0): begin addr = UNLOCK_A; code = CB_KEY1; end
      IDX_W'(1): begin addr = UNLOCK_B; code = CB_KEY2; end
      IDX_W'(2): begin addr = UNLOCK_A; code = CB_ARM;  end
      IDX_W'(3): begin addr = UNLOCK_A; code = CB_KEY1; end
      IDX_W'(4): begin addr = UNLOCK_B; code = CB_KEY2; end
      default: begin
        addr = (mode == ERS_CHIP) ? UNLOCK_A : target;
        code = final_code(mode);
      end
    endcase
  end

  generate
    if (DATA_W > 8) begin : g_wide
      assign data = {{(DATA_W-8){1'b0}}, code};
    end else begin : g_narrow
      assign data = code[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/nor_toggle_eval.sv
module nor_toggle_eval
  import nor_erase_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int TOGGLE_BIT = 6,
  parameter int TMO_BIT    = 5
) (
  input  logic [DATA_W-1:0] prev_stat,
  input  logic [DATA_W-1:0] cur_stat,
  input  ers_alg_e          alg,
  output logic              toggling,
  output logic              limit_hit
);
  assign toggling  = prev_stat[TOGGLE_BIT] ^ cur_stat[TOGGLE_BIT];
  assign limit_hit = (alg == ALG_STD) && cur_stat[TMO_BIT];
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nor_erase_pkg::*;
#(
  parameter int                ADDR_W     = 24,
  parameter int                DATA_W     = 16,
  parameter int                TOGGLE_BIT = 6,
  parameter int                TMO_BIT    = 5,
  parameter logic [ADDR_W-1:0] UNLOCK_A   = 'h555,
  parameter logic [ADDR_W-1:0] UNLOCK_B   = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              algo_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int              CMD_CYCLES = 6;
  localparam int              IDX_W      = $clog2(CMD_CYCLES);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CMD_CYCLES - 1);

  logic arst_n;

  ers_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  ers_mode_e         mode_q, mode_eff;
  ers_alg_e          alg_q;
  logic [ADDR_W-1:0] base_q;
  logic              ctx_en;
  logic [DATA_W-1:0] prev_q;
  logic              prev_en;
  logic              have_q, have_d, have_en;
  logic              done_q, done_d, err_q, err_d, flag_en;

  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              toggling, limit_hit;

  nor_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .arst_n (arst_n)
  );

  nor_mode_resolve u_resolve (
    .req_mode (ers_mode_e'(mode_i)),
    .alg      (ers_alg_e'(algo_i)),
    .eff_mode (mode_eff)
  );

  nor_cmd_table #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .UNLOCK_A (UNLOCK_A),
    .UNLOCK_B (UNLOCK_B)
  ) u_table (
    .idx    (idx_q),
    .mode   (mode_q),
    .target (base_q),
    .addr   (cmd_addr),
    .data   (cmd_data)
  );

  nor_toggle_eval #(
    .DATA_W     (DATA_W),
    .TOGGLE_BIT (TOGGLE_BIT),
    .TMO_BIT    (TMO_BIT)
  ) u_eval (
    .prev_stat (prev_q),
    .cur_stat  (bus_rdata_i),
    .alg       (alg_q),
    .toggling  (toggling),
    .limit_hit (limit_hit)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    ctx_en  = 1'b0;
    prev_en = 1'b0;
    have_d  = have_q;
    have_en = 1'b0;
    done_d  = done_q;
    err_d   = err_q;
    flag_en = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ctx_en  = 1'b1;
          idx_d   = '0;
          idx_en  = 1'b1;
          done_d  = 1'b0;
          err_d   = 1'b0;
          flag_en = 1'b1;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (bus_ack_i) begin
          if (idx_q == LAST_IDX) begin
            have_d  = 1'b0;
            have_en = 1'b1;
            state_d = ST_POLL;
          end else begin
            idx_d  = idx_q + IDX_W'(1);
            idx_en = 1'b1;
          end
        end
      end
      ST_POLL: begin
        if (bus_ack_i) begin
          if (!have_q) begin
            prev_en = 1'b1;
            have_d  = 1'b1;
            have_en = 1'b1;
          end else if (!toggling) begin
            done_d  = 1'b1;
            flag_en = 1'b1;
            state_d = ST_IDLE;
          end else if (limit_hit) begin
            prev_en = 1'b1;
            state_d = ST_CONF;
          end else begin
            prev_en = 1'b1;
          end
        end
      end
      ST_CONF: begin
        if (bus_ack_i) begin
          done_d  = 1'b1;
          err_d   = toggling;
          flag_en = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      mode_q  <= ERS_SECTOR;
      alg_q   <= ALG_STD;
      base_q  <= '0;
      prev_q  <= '0;
      have_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
      if (ctx_en) begin
        mode_q <= mode_eff;
        alg_q  <= ers_alg_e'(algo_i);
        base_q <= base_i;
      end
      if (prev_en) prev_q <= bus_rdata_i;
      if (have_en) have_q <= have_d;
      if (flag_en) begin
        done_q <= done_d;
        err_q  <= err_d;
      end
    end
  end

  // Outputs
  assign bus_we_o    = (state_q == ST_WR);
  assign bus_re_o    = (state_q == ST_POLL) || (state_q == ST_CONF);
  assign bus_addr_o  = bus_we_o ? cmd_addr : base_q;
  assign bus_wdata_o = bus_we_o ? cmd_data : '0;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;

endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we_o,
  input logic              bus_re_o,
  input logic              bus_ack_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);

  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we_o && bus_re_o));

  p_hold_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we_o && !bus_ack_i) |=> (bus_we_o && $stable(bus_addr_o) && $stable(bus_wdata_o)));

  p_hold_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re_o && !bus_ack_i) |=> (bus_re_o && $stable(bus_addr_o)));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bus_we_o && !bus_re_o));

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  p_done_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(bus_re_o && bus_ack_i));

endmodule

bind nor_erase_seq nor_erase_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_we_o    (bus_we_o),
  .bus_re_o    (bus_re_o),
  .bus_ack_i   (bus_ack_i),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/test_nor_erase_seq.sv
module test_nor_erase_seq;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  mode_i;
  logic        algo_i;
  logic [23:0] base_i;
  logic [23:0] bus_addr_o;
  logic [15:0] bus_wdata_o;
  logic        bus_we_o, bus_re_o;
  logic [15:0] bus_rdata_i;
  logic        bus_ack_i;
  logic        busy_o, done_o, err_o;

  int n_chk, n_fail;

  nor_erase_seq i_nor_erase_seq (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .mode_i (mode_i),
    .algo_i (algo_i), .base_i (base_i), .bus_addr_o (bus_addr_o),
    .bus_wdata_o (bus_wdata_o), .bus_we_o (bus_we_o), .bus_re_o (bus_re_o),
    .bus_rdata_i (bus_rdata_i), .bus_ack_i (bus_ack_i), .busy_o (busy_o),
    .done_o (done_o), .err_o (err_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Flash model: wait states, write log, scripted status reads
  int          wr_cnt, rd_cnt, m_tgl, m_b5, m_wait, wait_cnt, k_v;
  logic [23:0] wr_a [0:15];
  logic [15:0] wr_d [0:15];
  logic [23:0] last_rd_a;

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (bus_ack_i) begin
      bus_ack_i = 1'b0;
    end else if (bus_we_o || bus_re_o) begin
      if (wait_cnt < m_wait) begin
        wait_cnt++;
      end else begin
        wait_cnt  = 0;
        bus_ack_i = 1'b1;
        if (bus_we_o) begin
          if (wr_cnt < 16) begin
            wr_a[wr_cnt] = bus_addr_o;
            wr_d[wr_cnt] = bus_wdata_o;
          end
          wr_cnt++;
        end else begin
          k_v = (rd_cnt < m_tgl) ? rd_cnt : m_tgl - 1;
          bus_rdata_i    = 16'h0000;
          bus_rdata_i[6] = k_v[0];
          bus_rdata_i[5] = (rd_cnt >= m_b5);
          last_rd_a      = bus_addr_o;
          rd_cnt++;
        end
      end
    end
  end

  task automatic chk_eq(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run_case(string req, logic [1:0] md, logic alg, logic [23:0] base,
                          int tgl, int b5, int wt, logic [1:0] eff,
                          logic exp_err, int exp_reads, bit glitch);
    logic [23:0] fa;
    logic [15:0] fd;
    logic [23:0] ea [0:5];
    logic [15:0] ed [0:5];
    int n;
    fa = (eff == 2'b10) ? 24'h555 : base;
    fd = (eff == 2'b10) ? 16'h10 : (eff == 2'b01) ? 16'h50 : 16'h30;
    ea[0] = 24'h555; ed[0] = 16'hAA;
    ea[1] = 24'h2AA; ed[1] = 16'h55;
    ea[2] = 24'h555; ed[2] = 16'h80;
    ea[3] = 24'h555; ed[3] = 16'hAA;
    ea[4] = 24'h2AA; ed[4] = 16'h55;
    ea[5] = fa;      ed[5] = fd;

    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; m_tgl = tgl; m_b5 = b5; m_wait = wt;
    mode_i = md; algo_i = alg; base_i = base; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk_eq("R12", {req, " busy after start"}, busy_o, 1);
    chk_eq("R12", {req, " done cleared by start"}, done_o, 0);
    if (glitch) begin
      repeat (3) @(negedge clk);
      mode_i = 2'b10; base_i = 24'h0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk_eq(req, "done", done_o, 1);
    chk_eq(req, "err", err_o, exp_err);
    chk_eq(req, "busy at end", busy_o, 0);
    chk_eq("R1", {req, " write count"}, wr_cnt, 6);
    for (int i = 0; i < 6; i++) begin
      chk_eq(i < 5 ? "R1" : req, $sformatf("%s write %0d addr", req, i), wr_a[i], ea[i]);
      chk_eq(i < 5 ? "R1" : req, $sformatf("%s write %0d data", req, i), wr_d[i], ed[i]);
    end
    chk_eq(req, "status read count", rd_cnt, exp_reads);
    chk_eq("R7", {req, " status read address"}, last_rd_a, base);
  endtask

  task automatic t_reset;
    chk_eq("R12", "busy in reset", busy_o, 0);
    chk_eq("R12", "strobes in reset", {bus_we_o, bus_re_o}, 0);
    chk_eq("R12", "done/err in reset", {done_o, err_o}, 0);
  endtask

  task automatic t_sector;  run_case("R2", 2'b00, 1'b0, 24'h01_2000, 3, 1000, 0, 2'b00, 1'b0, 4, 1'b0); endtask
  task automatic t_block;   run_case("R3", 2'b01, 1'b1, 24'h04_0000, 2, 1000, 1, 2'b01, 1'b0, 3, 1'b0); endtask
  task automatic t_chip;
    run_case("R4", 2'b10, 1'b0, 24'h00_8000, 1, 1000, 0, 2'b10, 1'b0, 2, 1'b0);
    run_case("R4", 2'b10, 1'b1, 24'h00_9000, 4, 1000, 0, 2'b10, 1'b0, 5, 1'b0);
  endtask
  task automatic t_fallback; run_case("R5", 2'b01, 1'b0, 24'h0A_0000, 2, 1000, 0, 2'b00, 1'b0, 3, 1'b0); endtask
  task automatic t_rsvd;
    run_case("R6", 2'b11, 1'b0, 24'h0B_1000, 1, 1000, 0, 2'b00, 1'b0, 2, 1'b0);
    run_case("R6", 2'b11, 1'b1, 24'h0B_2000, 1, 1000, 0, 2'b00, 1'b0, 2, 1'b0);
  endtask
  task automatic t_poll_len; run_case("R7", 2'b00, 1'b1, 24'h10_0000, 7, 1000, 0, 2'b00, 1'b0, 8, 1'b0); endtask
  task automatic t_limit_err; run_case("R8", 2'b00, 1'b0, 24'h11_0000, 1000, 3, 0, 2'b00, 1'b1, 5, 1'b0); endtask
  task automatic t_limit_ok;  run_case("R9", 2'b00, 1'b0, 24'h12_0000, 3, 2, 1, 2'b00, 1'b0, 4, 1'b0); endtask
  task automatic t_ext_limit; run_case("R10", 2'b00, 1'b1, 24'h13_0000, 5, 1, 0, 2'b00, 1'b0, 6, 1'b0); endtask
  task automatic t_waits;     run_case("R11", 2'b00, 1'b0, 24'h14_0000, 2, 1000, 3, 2'b00, 1'b0, 3, 1'b1); endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL R12 watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    wr_cnt = 0; rd_cnt = 0; m_tgl = 1; m_b5 = 1000; m_wait = 0;
    last_rd_a = '0; bus_rdata_i = '0; bus_ack_i = 1'b0;
    start_i = 1'b0; mode_i = 2'b00; algo_i = 1'b0; base_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sector();
    t_block();
    t_chip();
    t_fallback();
    t_rsvd();
    t_poll_len();
    t_limit_err();
    t_limit_ok();
    t_ext_limit();
    t_waits();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule